// File: doc/BRIEF.md
# Dual-Pin GPIO Configuration Register

This block is one 8-bit control register that decides what two multifunction pins do. Each pin either keeps its dedicated input function or becomes a general-purpose I/O with its own direction and data bit. The second pin has a third use: it can drive an active-low interrupt that follows a registered interrupt-source input. Software reaches the register through a single-cycle write strobe and a read strobe with one cycle of latency.

A pin does not start driving the moment it is configured as an output. The block has to see the same value written twice in a row, which arms that pin's driver. Once the pin is armed, single writes change its output data. Leaving output configuration disarms it again. GPIO input levels are not reflected live in the register. They are captured into the data bit only when the register is written, so fresh input data needs a write followed by a read. Pin inputs pass through a synchronizer before use. The dedicated function is modelled as a pass-through of the synchronized pin level.

Top module: `dual_pin_cfg`

## Requirements
- R1: After reset the register reads 0x00, neither pin drives, and each dedicated output follows its synchronized pin input.
- R2: A read returns bit 7 as 0 and bits 6..0 as last written. The exception is a data bit whose pin the write made a GPIO input. Pin 1 uses bits 0 (function, 1 = GPIO), 1 (direction, 1 = output) and 2 (data). Pin 2 uses bits 3, 4 and 5 in the same roles. Bit 6 is the interrupt enable.
- R3: A pin becomes a driving output only once two consecutive writes carry identical values that set its function and direction bits both to 1. The first such write leaves the pin undriven.
- R4: While a pin is armed, a single write that keeps it a GPIO output updates its driven level from the new data bit in the following cycle.
- R5: A write that differs from the immediately preceding write does not arm a pin, even when both writes configure it as an output.
- R6: A write that takes a pin out of GPIO-output configuration stops its drive and clears its armed state. Returning to output then needs a fresh double write.
- R7: For a pin configured as a GPIO input, the data bit holds the synchronized pin level sampled in the write cycle. It does not change between writes, whatever the pin does.
- R8: When pin 2 is armed as an output and bit 6 is 1, pin 2 drives the inverse of the interrupt source as registered one cycle earlier.
- R9: When bit 6 is 1 but bits 4..3 are not both 1, pin 2 behaves exactly as bits 3..5 alone select.
- R10: Each dedicated output equals the synchronized pin level while that pin's function bit is 0, and is 0 while the bit is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Value to write |
| rd_en | input | 1 | Register read strobe; rd_data updates on the next edge |
| rd_data | output | 8 | Readback value |
| pin1_in | input | 1 | Level seen on pin 1 |
| pin2_in | input | 1 | Level seen on pin 2 |
| irq_src | input | 1 | Interrupt source, active high |
| pin1_oe | output | 1 | Pin 1 output enable |
| pin1_out | output | 1 | Pin 1 driven level |
| pin2_oe | output | 1 | Pin 2 output enable |
| pin2_out | output | 1 | Pin 2 driven level (data, or active-low interrupt) |
| ded1_out | output | 1 | Pin 1 dedicated-function input |
| ded2_out | output | 1 | Pin 2 dedicated-function input |

## Verification
The bench sweeps all 256 register values and writes each one first singly, then a second time. This exposes a design that arms on the first write, that drops an armed pin on a data-only update, or that lets bit 6 force interrupt mode without bits 4..3 set. Directed sequences cover a differing write placed between two output configurations, and re-entry to output after a trip through input mode. A design that compared against the configuration instead of the last write, or that kept the armed flag, would drive too early. Input readback is checked before and after a pin change with no write in between, which catches a design that tracks the pin continuously.

// File: rtl/pin_cfg_pkg.sv
package pin_cfg_pkg;
  localparam int REG_W     = 8;
  localparam int NPINS     = 2;
  localparam int PIN_BITS  = 3;                 // function, direction, data
  localparam int FUNC_OFS  = 0;
  localparam int DIR_OFS   = 1;
  localparam int DATA_OFS  = 2;
  localparam int IRQ_BIT   = NPINS * PIN_BITS;  // bit 6
  localparam int STORE_W   = REG_W - 1;         // bit 7 is not stored
  typedef logic [STORE_W-1:0] cfg_t;
endpackage

// File: rtl/pin_in_sync.sv
module pin_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q, chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/out_arm_track.sv
module out_arm_track (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic out_cfg_nx,   // the value being written makes this pin a GPIO output
  input  logic repeat_wr,    // the value being written equals the previous write
  output logic armed
);
  logic armed_q, armed_d;

  always_comb begin
    armed_d = armed_q;
    if (wr_en) armed_d = out_cfg_nx & (armed_q | repeat_wr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end

  assign armed = armed_q;

  // R3
  arm_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_q) |-> $past(wr_en) && $past(repeat_wr));
  // R6
  arm_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !out_cfg_nx) |=> !armed_q);
endmodule

// File: rtl/dual_pin_cfg.sv
module dual_pin_cfg
  import pin_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  input  logic       pin1_in,
  input  logic       pin2_in,
  input  logic       irq_src,
  output logic       pin1_oe,
  output logic       pin1_out,
  output logic       pin2_oe,
  output logic       pin2_out,
  output logic       ded1_out,
  output logic       ded2_out
);
  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [NPINS-1:0] pin_raw, pin_s, armed, out_cfg_nx, ded;
  cfg_t             cfg_q, cfg_d;
  logic [REG_W-1:0] last_q, last_d, rd_q, rd_d;
  logic             last_vld_q, last_vld_d;
  logic             irq_q;
  logic             repeat_wr, irq_mode;

  assign pin_raw   = {pin2_in, pin1_in};
  assign repeat_wr = last_vld_q && (wr_data == last_q);

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    localparam int B = g * PIN_BITS;
    pin_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_sync_n), .d(pin_raw[g]), .q(pin_s[g]));
    assign out_cfg_nx[g] = wr_data[B + FUNC_OFS] & wr_data[B + DIR_OFS];
    out_arm_track u_arm (
      .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en),
      .out_cfg_nx(out_cfg_nx[g]), .repeat_wr(repeat_wr), .armed(armed[g]));
    assign ded[g] = cfg_q[B + FUNC_OFS] ? 1'b0 : pin_s[g];
  end

  // next state
  always_comb begin
    cfg_d      = cfg_q;
    last_d     = last_q;
    last_vld_d = last_vld_q;
    if (wr_en) begin
      cfg_d      = wr_data[STORE_W-1:0];
      last_d     = wr_data;
      last_vld_d = 1'b1;
      for (int i = 0; i < NPINS; i++) begin
        if (wr_data[i*PIN_BITS + FUNC_OFS] && !wr_data[i*PIN_BITS + DIR_OFS])
          cfg_d[i*PIN_BITS + DATA_OFS] = pin_s[i];
      end
    end
    rd_d = rd_en ? {1'b0, cfg_q} : rd_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cfg_q      <= '0;
      last_q     <= '0;
      last_vld_q <= 1'b0;
      rd_q       <= '0;
      irq_q      <= 1'b0;
    end else begin
      cfg_q      <= cfg_d;
      last_q     <= last_d;
      last_vld_q <= last_vld_d;
      rd_q       <= rd_d;
      irq_q      <= irq_src;
    end
  end

  assign irq_mode = armed[1] & cfg_q[IRQ_BIT];

  assign rd_data  = rd_q;
  assign pin1_oe  = armed[0];
  assign pin1_out = armed[0] & cfg_q[DATA_OFS];
  assign pin2_oe  = armed[1];
  assign pin2_out = irq_mode ? ~irq_q : (armed[1] & cfg_q[PIN_BITS + DATA_OFS]);
  assign ded1_out = ded[0];
  assign ded2_out = ded[1];

  // R2
  rd_msb_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_data[REG_W-1] == 1'b0);
  // R6
  p1_drive_cfg_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pin1_oe |-> (cfg_q[DIR_OFS:FUNC_OFS] == 2'b11));
  // R6
  p2_drive_cfg_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pin2_oe |-> (cfg_q[PIN_BITS+DIR_OFS:PIN_BITS+FUNC_OFS] == 2'b11));
  // R7
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !wr_en |=> $stable(cfg_q));
  // R8
  irq_drive_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (irq_mode && $past(irq_src)) |-> (pin2_oe && !pin2_out));
  // R10
  ded_gpio_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cfg_q[FUNC_OFS] |-> !ded1_out);
endmodule

// File: tb/test_dual_pin_cfg.sv
`timescale 1ns/1ps
module test_dual_pin_cfg;
  logic       clk = 1'b0;
  logic       rst_n, wr_en, rd_en, pin1_in, pin2_in, irq_src;
  logic [7:0] wr_data, rd_data;
  logic       pin1_oe, pin1_out, pin2_oe, pin2_out, ded1_out, ded2_out;
  int         n_chk = 0;
  int         n_err = 0;
  bit         done  = 1'b0;

  always #2.5 clk = ~clk;

  dual_pin_cfg i_dual_pin_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .pin1_in(pin1_in), .pin2_in(pin2_in),
    .irq_src(irq_src), .pin1_oe(pin1_oe), .pin1_out(pin1_out),
    .pin2_oe(pin2_oe), .pin2_out(pin2_out), .ded1_out(ded1_out),
    .ded2_out(ded2_out));

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd();
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  function automatic logic [7:0] exp_rd(logic [7:0] v, logic p1, logic p2);
    logic [7:0] e;
    e = {1'b0, v[6:0]};
    if (v[1:0] == 2'b01) e[2] = p1;
    if (v[4:3] == 2'b01) e[5] = p2;
    return e;
  endfunction

  initial begin
    idle(200000);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] prev;
    logic a1, a2;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
    pin1_in = 1'b1; pin2_in = 1'b0; irq_src = 1'b1;
    idle(3);
    rst_n = 1'b1;
    idle(6);
    // R1: reset state
    chk("R1 rd_data", rd_data, 0);
    chk("R1 pin1_oe", pin1_oe, 0);
    chk("R1 pin2_oe", pin2_oe, 0);
    chk("R1 ded1_out", ded1_out, 1);
    rd();
    chk("R1 read", rd_data, 8'h00);

    // sweep every value: single write then repeat
    wr(8'h00); wr(8'h00);
    prev = 8'h00;
    for (int v = 0; v < 256; v++) begin
      logic [7:0] val;
      val = v[7:0];
      wr(val);
      a1 = (val[1:0] == 2'b11) && (prev[1:0] == 2'b11);
      a2 = (val[4:3] == 2'b11) && (prev[4:3] == 2'b11);
      // R3 first write, R4 single-write update when already armed
      chk("R3 p1 oe single", pin1_oe, a1);
      chk("R3 p2 oe single", pin2_oe, a2);
      if (a1) chk("R4 p1 data", pin1_out, val[2]);
      wr(val);
      a1 = (val[1:0] == 2'b11);
      a2 = (val[4:3] == 2'b11);
      chk("R3 p1 oe double", pin1_oe, a1);
      chk("R3 p2 oe double", pin2_oe, a2);
      if (a1) chk("R4 p1 level", pin1_out, val[2]);
      // R8 irq_src=1 gives low; R9 otherwise data bit
      if (a2) chk("R8 R9 p2 level", pin2_out, val[6] ? 0 : val[5]);
      chk("R10 ded1", ded1_out, val[0] ? 0 : 1);
      rd();
      chk("R2 readback", rd_data, exp_rd(val, 1'b1, 1'b0));
      prev = val;
    end

    // R7: capture only on write
    pin1_in = 1'b0; idle(4);
    wr(8'h01); rd();
    chk("R7 capture low", rd_data, 8'h01);
    pin1_in = 1'b1; idle(4); rd();
    chk("R7 held without write", rd_data, 8'h01);
    wr(8'h01); rd();
    chk("R7 refreshed by write", rd_data, 8'h05);

    // R5: differing consecutive output writes do not arm
    wr(8'h00); wr(8'h00);
    wr(8'h07); wr(8'h03);
    chk("R5 differ no arm", pin1_oe, 0);
    wr(8'h03);
    chk("R5 repeat arms", pin1_oe, 1);
    chk("R4 level low", pin1_out, 0);
    wr(8'h07);
    chk("R4 single update", pin1_out, 1);

    // R6: leave output then re-enter
    wr(8'h01);
    chk("R6 drop on input", pin1_oe, 0);
    wr(8'h03);
    chk("R6 re-entry single", pin1_oe, 0);
    wr(8'h03);
    chk("R6 re-entry double", pin1_oe, 1);

    // R8: interrupt follows registered source, active low
    wr(8'h58); wr(8'h58);
    chk("R8 oe", pin2_oe, 1);
    irq_src = 1'b0; @(negedge clk);
    chk("R8 idle high", pin2_out, 1);
    irq_src = 1'b1; @(negedge clk);
    chk("R8 active low", pin2_out, 0);

    // R9: bit 6 with pin 2 as GPIO input has no output effect
    wr(8'h48); wr(8'h48);
    chk("R9 no drive", pin2_oe, 0);

    // R10: pin 2 dedicated pass-through
    wr(8'h00);
    pin2_in = 1'b1; idle(4);
    chk("R10 ded2 follows", ded2_out, 1);
    wr(8'h08);
    chk("R10 ded2 gpio zero", ded2_out, 0);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule